// File: doc/BRIEF.md
# Shared Pin Port with Pull-up Fallback

This block is a sixteen-pin general-purpose port that two agents drive at once. The CPU reaches it over a simple valid/write register bus. A peripheral agent drives pins through its own direction and data inputs. For every pin, one control word holds two adjacent bits: an output enable and a pull-up enable. A data register holds the levels the CPU wants to drive. The block computes the level of each pin from the two drivers. A pin that neither agent drives falls back to its pull-up.

Up to four listeners watch the port. On every CPU write to the control or data register, the block compares the resolved pin vector before and after the write. Each listener whose trigger mask overlaps the changed pins gets a one-cycle notification pulse. The resolved pin vector is presented alongside the pulse. Changes that come only from the peripheral side never raise a notification.

Top module: `gpio_share_port`

## Requirements
- R1: After a synchronous active-low reset, the control word and the data register are zero. The resolved pin vector reads 0 and no notification is active.
- R2: Control word bit 2n enables the CPU output on pin n, and bit 2n+1 enables the pull-up on pin n. The control word is written and read at byte address 0x0, and a read returns the last value written.
- R3: Pin n resolves high when any of these holds: (CPU enable and CPU data), (peripheral enable and peripheral data), or (neither agent enables the pin and its pull-up is on). Otherwise pin n resolves low.
- R4: The data register is written at byte address 0x4 from the low 16 bits of the write data. A read at 0x4 returns the resolved pin levels, zero-extended, and not the written data latch.
- R5: A write to 0x0 or 0x4 that leaves the resolved vector unchanged produces no notification.
- R6: After a write that changes the resolved vector, listener k pulses its notify bit for exactly one cycle, in the cycle after the write. It pulses only if its 16-bit trigger mask ANDed with the changed pins (old XOR new) is nonzero.
- R7: Changes to the peripheral direction or data inputs show on the resolved vector in the same cycle but never produce a notification.
- R8: Writes to any other address, and read cycles at any address, leave the control word and the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Bus cycle request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| per_dir | input | 16 | Peripheral output enables |
| per_dat | input | 16 | Peripheral output data |
| trig_mask | input | 64 | Listener k mask in bits [16k+15:16k] |
| pin_level | output | 16 | Resolved pin vector |
| notify | output | 4 | Per-listener change pulse |

## Verification
A corrupted control or data register shows on pin_level at once, and in the value read back at 0x4. The data path is combinational, so a fault is visible within the same cycle. A wrong old/new comparison or a wrong mask qualification shows as a notify bit that is missing, extra, or lasting longer than one cycle. Any of these appears in the single cycle after the offending write. Peripheral-only changes are exercised separately, to prove that they move pin_level without pulsing any listener.

// File: rtl/gpio_share_pkg.sv
// Shared constants for the shared pin port.
// Assumes byte addressing on the register bus.
package gpio_share_pkg;
    localparam int CTRL_OFS = 'h0;
    localparam int DATA_OFS = 'h4;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_DATA = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/gpio_ctrl_regs.sv
// Register file: decodes bus cycles and holds the control word and data latch.
// Splits the interleaved control word into direction and pull-up vectors.
// Exports both current and next-state copies for change detection.
// Assumes single-cycle writes and a combinational read path.
module gpio_ctrl_regs
    import gpio_share_pkg::*;
#(
    parameter int PINS   = 16,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2*PINS-1:0]   bus_wdata,
    input  logic [PINS-1:0]     pin_level,
    output logic [2*PINS-1:0]   bus_rdata,
    output logic [2*PINS-1:0]   ctrl_q,
    output logic [PINS-1:0]     data_q,
    output logic [PINS-1:0]     dir_q,
    output logic [PINS-1:0]     pull_q,
    output logic [PINS-1:0]     data_nxt,
    output logic [PINS-1:0]     dir_nxt,
    output logic [PINS-1:0]     pull_nxt,
    output logic                wr_hit
);
    localparam int CW = 2 * PINS;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

    reg_sel_e        sel;
    logic [CW-1:0]   ctrl_nxt;

    // Address decode into a register select.
    always_comb begin
        if (bus_addr == CTRL_A)      sel = SEL_CTRL;
        else if (bus_addr == DATA_A) sel = SEL_DATA;
        else                         sel = SEL_NONE;
    end

    assign wr_hit = bus_valid && bus_write && (sel != SEL_NONE);

    // Next-state values as they will be after this cycle's edge.
    always_comb begin
        ctrl_nxt = ctrl_q;
        data_nxt = data_q;
        if (bus_valid && bus_write && sel == SEL_CTRL) ctrl_nxt = bus_wdata;
        if (bus_valid && bus_write && sel == SEL_DATA) data_nxt = bus_wdata[PINS-1:0];
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            data_q <= '0;
        end else begin
            ctrl_q <= ctrl_nxt;
            data_q <= data_nxt;
        end
    end

    // De-interleave: even bits are enables, odd bits are pull-ups.
    for (genvar n = 0; n < PINS; n++) begin : g_split
        assign dir_q[n]    = ctrl_q[2*n];
        assign pull_q[n]   = ctrl_q[2*n+1];
        assign dir_nxt[n]  = ctrl_nxt[2*n];
        assign pull_nxt[n] = ctrl_nxt[2*n+1];
    end

    // Read mux: data address returns resolved levels.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL: bus_rdata = ctrl_q;
            SEL_DATA: bus_rdata = {{(CW-PINS){1'b0}}, pin_level};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_resolve.sv
// Per-pin level resolution between CPU drive, peripheral drive and pull-up.
// Pure combinational; one identical cell per pin.
module gpio_pin_resolve #(
    parameter int PINS = 16
) (
    input  logic [PINS-1:0] cpu_dir,
    input  logic [PINS-1:0] cpu_dat,
    input  logic [PINS-1:0] pull_en,
    input  logic [PINS-1:0] per_dir,
    input  logic [PINS-1:0] per_dat,
    output logic [PINS-1:0] level
);
    for (genvar n = 0; n < PINS; n++) begin : g_pin
        logic cpu_hi, per_hi, float_hi;
        // Each driver contributes a high only when it is enabled.
        assign cpu_hi   = cpu_dir[n] & cpu_dat[n];
        assign per_hi   = per_dir[n] & per_dat[n];
        assign float_hi = ~(cpu_dir[n] | per_dir[n]) & pull_en[n];
        assign level[n] = cpu_hi | per_hi | float_hi;
    end
endmodule

// File: rtl/gpio_change_notify.sv
// Change detector: on a register write, compares resolved levels before
// and after, and pulses each listener whose mask covers a changed pin.
// Assumes peripheral inputs are steady across the write cycle.
module gpio_change_notify #(
    parameter int PINS      = 16,
    parameter int LISTENERS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_hit,
    input  logic [PINS-1:0]             old_lvl,
    input  logic [PINS-1:0]             new_lvl,
    input  logic [LISTENERS*PINS-1:0]   trig_mask,
    output logic [LISTENERS-1:0]        notify
);
    logic [PINS-1:0] changed;
    assign changed = old_lvl ^ new_lvl;

    for (genvar k = 0; k < LISTENERS; k++) begin : g_lst
        logic hit;
        assign hit = wr_hit && (|(trig_mask[k*PINS +: PINS] & changed));
        // One-cycle pulse registered at the write edge.
        always_ff @(posedge clk) begin
            if (!rst_n) notify[k] <= 1'b0;
            else        notify[k] <= hit;
        end
    end
endmodule

// File: rtl/gpio_share_port.sv
// Top: shared sixteen-pin port with two drivers, pull-up fallback and
// per-listener change notification on CPU register writes.
module gpio_share_port #(
    parameter int PINS      = 16,
    parameter int LISTENERS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [2*PINS-1:0]           bus_wdata,
    output logic [2*PINS-1:0]           bus_rdata,
    input  logic [PINS-1:0]             per_dir,
    input  logic [PINS-1:0]             per_dat,
    input  logic [LISTENERS*PINS-1:0]   trig_mask,
    output logic [PINS-1:0]             pin_level,
    output logic [LISTENERS-1:0]        notify
);
    logic [2*PINS-1:0] ctrl_q;
    logic [PINS-1:0]   data_q, dir_q, pull_q;
    logic [PINS-1:0]   data_nxt, dir_nxt, pull_nxt;
    logic [PINS-1:0]   lvl_nxt;
    logic              wr_hit;

    gpio_ctrl_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .pin_level(pin_level), .bus_rdata(bus_rdata),
        .ctrl_q(ctrl_q), .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q),
        .data_nxt(data_nxt), .dir_nxt(dir_nxt), .pull_nxt(pull_nxt),
        .wr_hit(wr_hit)
    );

    // Levels as they stand now.
    gpio_pin_resolve #(.PINS(PINS)) u_now (
        .cpu_dir(dir_q), .cpu_dat(data_q), .pull_en(pull_q),
        .per_dir(per_dir), .per_dat(per_dat), .level(pin_level)
    );

    // Levels as they will stand after this cycle's write.
    gpio_pin_resolve #(.PINS(PINS)) u_next (
        .cpu_dir(dir_nxt), .cpu_dat(data_nxt), .pull_en(pull_nxt),
        .per_dir(per_dir), .per_dat(per_dat), .level(lvl_nxt)
    );

    gpio_change_notify #(.PINS(PINS), .LISTENERS(LISTENERS)) u_notify (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
        .old_lvl(pin_level), .new_lvl(lvl_nxt),
        .trig_mask(trig_mask), .notify(notify)
    );
endmodule

// File: rtl/gpio_share_port_chk.sv
// Checker for the shared pin port, attached to the top through bind.
module gpio_share_port_chk #(
    parameter int PINS      = 16,
    parameter int LISTENERS = 4,
    parameter int ADDR_W    = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_valid,
    input logic                      bus_write,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [2*PINS-1:0]         bus_rdata,
    input logic [PINS-1:0]           per_dir,
    input logic [PINS-1:0]           pin_level,
    input logic [LISTENERS-1:0]      notify,
    input logic [2*PINS-1:0]         ctrl_q,
    input logic [PINS-1:0]           data_q
);
    logic [PINS-1:0] c_dir, c_pull;
    logic            c_wr;
    for (genvar n = 0; n < PINS; n++) begin : g_f
        assign c_dir[n]  = ctrl_q[2*n];
        assign c_pull[n] = ctrl_q[2*n+1];
    end
    assign c_wr = bus_valid && bus_write &&
                  (bus_addr == ADDR_W'('h0) || bus_addr == ADDR_W'('h4));

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (notify == '0 && ctrl_q == '0 && data_q == '0)); // R1
    AST_NO_SOURCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_level & ~(c_dir | per_dir | c_pull)) == '0); // R3
    AST_CPU_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_dir & ~per_dir) & (pin_level ^ data_q)) == '0); // R3
    AST_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == ADDR_W'('h4)) |-> bus_rdata[PINS-1:0] == pin_level); // R4
    AST_NOTIFY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && notify != '0) |-> $past(c_wr)); // R7
    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !c_wr |=> ($stable(ctrl_q) && $stable(data_q))); // R8
endmodule

bind gpio_share_port gpio_share_port_chk #(
    .PINS(PINS), .LISTENERS(LISTENERS), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .per_dir(per_dir),
    .pin_level(pin_level), .notify(notify), .ctrl_q(ctrl_q), .data_q(data_q)
);

// File: tb/tb_gpio_share_port.sv
module tb_gpio_share_port;
    localparam int PINS = 16;
    localparam int LST  = 4;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              bus_valid = 0, bus_write = 0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [15:0]       per_dir = '0, per_dat = '0;
    logic [63:0]       trig_mask = '0;
    logic [15:0]       pin_level;
    logic [3:0]        notify;

    int n_tests = 0, n_fail = 0;
    logic [31:0] m_ctrl = '0;
    logic [15:0] m_data = '0;

    always #5 clk = ~clk;

    gpio_share_port dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .per_dir(per_dir), .per_dat(per_dat), .trig_mask(trig_mask),
        .pin_level(pin_level), .notify(notify)
    );

    function automatic logic [15:0] model_level();
        logic [15:0] r;
        for (int n = 0; n < PINS; n++) begin
            logic d, p;
            d = m_ctrl[2*n];
            p = m_ctrl[2*n+1];
            r[n] = (d & m_data[n]) | (per_dir[n] & per_dat[n]) | (~(d | per_dir[n]) & p);
        end
        return r;
    endfunction

    function automatic logic [3:0] model_notify(logic [15:0] chg);
        logic [3:0] r;
        for (int k = 0; k < LST; k++) r[k] = |(trig_mask[k*16 +: 16] & chg);
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write one register; checks notify in the cycle after and its clearing.
    task automatic bus_wr(logic [7:0] a, logic [31:0] d, string req);
        logic [15:0] old_l, new_l;
        logic [3:0]  exp_n;
        @(negedge clk);
        old_l = model_level();
        if (a == 8'h0) m_ctrl = d;
        if (a == 8'h4) m_data = d[15:0];
        new_l = model_level();
        exp_n = model_notify(old_l ^ new_l);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        check(notify == exp_n, req, {28'd0, notify}, {28'd0, exp_n});
        check(pin_level == new_l, req, {16'd0, pin_level}, {16'd0, new_l});
        @(negedge clk);
        check(notify == 4'd0, {req, " pulse"}, {28'd0, notify}, 32'd0);
    endtask

    task automatic bus_rd(logic [7:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic t_reset();
        check(pin_level == 0, "R1", {16'd0, pin_level}, 0);
        check(notify == 0, "R1", {28'd0, notify}, 0);
        bus_rd(8'h0, 32'h0, "R1");
        bus_rd(8'h4, 32'h0, "R1");
    endtask

    task automatic t_fields();
        bus_wr(8'h0, 32'hA5A5_3C3C, "R2");
        bus_rd(8'h0, 32'hA5A5_3C3C, "R2");
        bus_wr(8'h0, 32'h0000_0001, "R2");
        bus_wr(8'h4, 32'h0000_0001, "R2");
        check(pin_level[0] == 1'b1, "R2 enable bit0", {31'd0, pin_level[0]}, 1);
        bus_wr(8'h4, 32'h0, "R2");
        bus_wr(8'h0, 32'h0000_0008, "R2");
        check(pin_level == 16'h0002, "R2 pullup bit3", {16'd0, pin_level}, 32'h2);
    endtask

    task automatic t_resolve();
        per_dir = 16'h00F0; per_dat = 16'h0030;
        bus_wr(8'h0, 32'hAAAA_5555, "R3");
        bus_wr(8'h4, 32'h0000_0F0F, "R3");
        bus_rd(8'h4, {16'd0, model_level()}, "R3");
        per_dir = 16'hFF00; per_dat = 16'h5A00;
        bus_wr(8'h0, 32'hFFFF_0000, "R3");
        bus_rd(8'h4, {16'd0, model_level()}, "R3");
        per_dir = 0; per_dat = 0;
        @(negedge clk);
    endtask

    task automatic t_readback();
        bus_wr(8'h0, 32'h0, "R4");
        bus_wr(8'h4, 32'h0000_FFFF, "R4");
        bus_rd(8'h4, 32'h0, "R4 latch not visible");
    endtask

    task automatic t_nochange();
        trig_mask = {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};
        bus_wr(8'h4, 32'h0000_1234, "R5");
        bus_wr(8'h0, 32'h0000_0000, "R5");
        bus_wr(8'h4, 32'h0000_4321, "R5");
    endtask

    task automatic t_masks();
        trig_mask = {16'h0000, 16'hFFFF, 16'h0002, 16'h0001};
        bus_wr(8'h4, 32'h0, "R6");
        bus_wr(8'h0, 32'h0000_0005, "R6");
        bus_wr(8'h4, 32'h0000_0001, "R6");
        check(notify == 0, "R6 after pulse", {28'd0, notify}, 0);
        bus_wr(8'h4, 32'h0000_0003, "R6");
        bus_wr(8'h4, 32'h0000_0000, "R6");
    endtask

    task automatic t_periph();
        logic [15:0] exp_l;
        trig_mask = {4{16'hFFFF}};
        @(negedge clk);
        per_dir = 16'hFFFF; per_dat = 16'hC3C3;
        #1;
        exp_l = model_level();
        check(pin_level == exp_l, "R7 level", {16'd0, pin_level}, {16'd0, exp_l});
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(notify == 0, "R7 quiet", {28'd0, notify}, 0);
        end
        per_dir = 0; per_dat = 0;
        @(negedge clk);
    endtask

    task automatic t_ignored();
        bus_wr(8'h0, 32'h1357_9BDF, "R8");
        bus_wr(8'h8, 32'hFFFF_FFFF, "R8");
        bus_rd(8'h0, 32'h1357_9BDF, "R8 unmapped");
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = 8'h0; bus_wdata = 32'h0;
        @(negedge clk);
        bus_valid = 0;
        bus_rd(8'h0, 32'h1357_9BDF, "R8 read cycle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_resolve();
        t_readback();
        t_nochange();
        t_masks();
        t_periph();
        t_ignored();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule